// File: doc/BRIEF.md
# Machine Timer with Cycle-Exact Blocking Wait

This block is a memory-mapped machine timer for a processor subsystem. It holds a 64-bit time counter that advances by one on every clock, and a 64-bit compare value that raises a level-sensitive timer interrupt once the counter has reached it. Software reads and writes both through a small request/acknowledge register port. Each 64-bit value appears as two 32-bit words.

The block also has a synchronising wait register. A bus write to it is not acknowledged until the low byte of the time counter equals the low byte of the written data. The processor's store stalls until then, so the instruction after the store runs on a known clock cycle. An interrupt handler entered a little early, and with a variable entry delay, can use this to line up with an exact tick and remove the jitter. A separate disable register turns the compare off and drops the interrupt.

Top module: `mtimer_blk`

## Requirements
- R1: After reset the time counter is 0, and it then rises by exactly one on every clock cycle with no word write to it.
- R2: A write to byte offset 0x00 (time bits 31:0) or 0x04 (time bits 63:32) replaces that word at the clock edge. The counter does not advance on that edge, and it counts on from the written value in the next cycle.
- R3: A read returns time bits 31:0 at 0x00, time bits 63:32 at 0x04, compare bits 31:0 at 0x08 and compare bits 63:32 at 0x0C. Reads of 0x10, 0x14 and every unmapped offset return zero.
- R4: A write to 0x08 or 0x0C sets that compare word and arms the compare. While armed, timer_irq is high whenever the time is greater than or equal to the compare value, as unsigned 64-bit numbers.
- R5: Once asserted, timer_irq stays high while the compare condition holds. It falls only when the compare is disabled or rewritten to a value above the current time.
- R6: A write of any value to 0x14 disarms the compare, sets both compare words to all ones and drives timer_irq low from the next cycle.
- R7: Reset leaves the compare disarmed, with both words all ones, and timer_irq low.
- R8: A write to 0x10 is held, with bus_ack low, until time bits 7:0 equal bus_wdata bits 7:0. bus_ack rises in that matching cycle, and in the same cycle if the byte already matches. The upper write data bits are ignored, and no wait lasts more than 255 cycles.
- R9: Every access other than a write to 0x10 is acknowledged in the same cycle that bus_req is raised. bus_ack is never high without bus_req.
- R10: Writes to unmapped offsets change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (5) | Byte offset of the register |
| bus_wdata | input | WORD_W (32) | Write data |
| bus_rdata | output | WORD_W (32) | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | Access completes on the clock edge where this is high |
| timer_irq | output | 1 | Level timer interrupt |

## Verification
The hardest case to reach from the ports is the wait register held for an exact, chosen number of cycles, including the zero-stall case and the longest 255-cycle stall. The counter keeps running, so the bench cannot fix its value in advance. Instead it reads the low time word and issues the wait write in the very next cycle, when the counter is known to be one higher. It aims the target byte at a chosen offset from that value, counts the cycles with the acknowledge low, and reads the time again straight after release to confirm the exact alignment.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    localparam int WORD_W_DEF = 32;
    localparam int ADDR_W_DEF = 5;
    localparam int SYNC_W_DEF = 8;

    // Byte offsets of the register map
    localparam logic [7:0] OFS_TIME_LO = 8'h00;
    localparam logic [7:0] OFS_TIME_HI = 8'h04;
    localparam logic [7:0] OFS_CMP_LO  = 8'h08;
    localparam logic [7:0] OFS_CMP_HI  = 8'h0C;
    localparam logic [7:0] OFS_SYNC    = 8'h10;
    localparam logic [7:0] OFS_CMP_OFF = 8'h14;

    typedef enum logic [2:0] {
        SEL_TIME_LO,
        SEL_TIME_HI,
        SEL_CMP_LO,
        SEL_CMP_HI,
        SEL_SYNC,
        SEL_CMP_OFF,
        SEL_NONE
    } reg_sel_e;

    // One write strobe per writable state word
    typedef struct packed {
        logic time_lo;
        logic time_hi;
        logic cmp_lo;
        logic cmp_hi;
        logic cmp_off;
    } wr_stb_t;

    function automatic reg_sel_e decode_sel(input logic [7:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_TIME_LO: s = SEL_TIME_LO;
            OFS_TIME_HI: s = SEL_TIME_HI;
            OFS_CMP_LO:  s = SEL_CMP_LO;
            OFS_CMP_HI:  s = SEL_CMP_HI;
            OFS_SYNC:    s = SEL_SYNC;
            OFS_CMP_OFF: s = SEL_CMP_OFF;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
    parameter int WORD_W = mtmr_pkg::WORD_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  ld_lo,
    input  logic                  ld_hi,
    input  logic [WORD_W-1:0]     ld_data,
    output logic [2*WORD_W-1:0]   count
);
    localparam int TIME_W = 2 * WORD_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (ld_lo) begin
            count[WORD_W-1:0] <= ld_data;
        end else if (ld_hi) begin
            count[TIME_W-1:WORD_W] <= ld_data;
        end else begin
            count <= count + TIME_W'(1);
        end
    end

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R1: steady single-step advance
    p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
        seen && !$past(ld_lo) && !$past(ld_hi) |-> count == $past(count) + TIME_W'(1));

    // R2: a load replaces the word and suppresses the step
    p_load_lo_r2: assert property (@(posedge clk) disable iff (rst)
        seen && $past(ld_lo) |-> count[WORD_W-1:0] == $past(ld_data)
                                 && count[TIME_W-1:WORD_W] == $past(count[TIME_W-1:WORD_W]));
endmodule

// File: rtl/mtmr_compare.sv
module mtmr_compare #(
    parameter int WORD_W = mtmr_pkg::WORD_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic                  disarm,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [2*WORD_W-1:0]   time_now,
    output logic [2*WORD_W-1:0]   cmp_val,
    output logic                  irq
);
    localparam int TIME_W = 2 * WORD_W;

    logic armed;

    always_ff @(posedge clk) begin
        if (rst || disarm) begin
            cmp_val <= '1;
            armed   <= 1'b0;
        end else begin
            if (wr_lo) begin
                cmp_val[WORD_W-1:0] <= wdata;
                armed <= 1'b1;
            end
            if (wr_hi) begin
                cmp_val[TIME_W-1:WORD_W] <= wdata;
                armed <= 1'b1;
            end
        end
    end

    assign irq = armed && (time_now >= cmp_val);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R6: disarming forces all ones and silences the line
    p_disarm_clears_r6: assert property (@(posedge clk) disable iff (rst)
        seen && $past(disarm) |-> cmp_val == '1 && !irq);

    // R5: level held while nothing touches compare and time keeps rising
    p_irq_holds_r5: assert property (@(posedge clk) disable iff (rst)
        seen && $past(irq) && !$past(wr_lo) && !$past(wr_hi) && !$past(disarm)
        && (time_now == $past(time_now) + TIME_W'(1)) |-> irq);

    // R4: a compare write arms the comparison
    p_write_arms_r4: assert property (@(posedge clk) disable iff (rst)
        seen && ($past(wr_lo) || $past(wr_hi)) && !$past(disarm)
        && time_now >= cmp_val |-> irq);
endmodule

// File: rtl/mtmr_sync_wait.sv
module mtmr_sync_wait #(
    parameter int SYNC_W = mtmr_pkg::SYNC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic [SYNC_W-1:0] target,
    input  logic [SYNC_W-1:0] time_low,
    output logic              release_now
);
    localparam int CNT_W     = SYNC_W + 1;
    localparam int MAX_STALL = (1 << SYNC_W) - 1;

    assign release_now = hold && (time_low == target);

    // Cycles spent stalled in the current wait
    logic [CNT_W-1:0] stall_cnt;
    always_ff @(posedge clk) begin
        if (rst || !hold || release_now) stall_cnt <= '0;
        else                             stall_cnt <= stall_cnt + CNT_W'(1);
    end

    // R8: a wait never lasts longer than one lap of the low byte
    p_stall_bound_r8: assert property (@(posedge clk) disable iff (rst)
        stall_cnt <= CNT_W'(MAX_STALL));
endmodule

// File: rtl/mtmr_regif.sv
module mtmr_regif
    import mtmr_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int SYNC_W = SYNC_W_DEF
) (
    input  logic                  req,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic                  sync_release,
    input  logic [2*WORD_W-1:0]   time_q,
    input  logic [2*WORD_W-1:0]   cmp_q,
    output logic                  ack,
    output logic [WORD_W-1:0]     rdata,
    output wr_stb_t               stb,
    output logic                  sync_hold,
    output logic [SYNC_W-1:0]     sync_target
);
    localparam int TIME_W = 2 * WORD_W;

    reg_sel_e sel;
    logic     wr_go;

    always_comb begin
        sel         = decode_sel(8'(addr));
        sync_hold   = req && we && (sel == SEL_SYNC);
        sync_target = wdata[SYNC_W-1:0];
        ack         = sync_hold ? sync_release : req;
        wr_go       = req && we && ack;

        stb.time_lo = wr_go && (sel == SEL_TIME_LO);
        stb.time_hi = wr_go && (sel == SEL_TIME_HI);
        stb.cmp_lo  = wr_go && (sel == SEL_CMP_LO);
        stb.cmp_hi  = wr_go && (sel == SEL_CMP_HI);
        stb.cmp_off = wr_go && (sel == SEL_CMP_OFF);

        case (sel)
            SEL_TIME_LO: rdata = time_q[WORD_W-1:0];
            SEL_TIME_HI: rdata = time_q[TIME_W-1:WORD_W];
            SEL_CMP_LO:  rdata = cmp_q[WORD_W-1:0];
            SEL_CMP_HI:  rdata = cmp_q[TIME_W-1:WORD_W];
            default:     rdata = '0;
        endcase
    end

    // R9: at most one state strobe per access
    always_comb begin
        a_one_strobe_r9: assert ($countones(stb) <= 1);
    end
endmodule

// File: rtl/mtimer_blk.sv
module mtimer_blk
    import mtmr_pkg::*;
#(
    parameter int WORD_W = WORD_W_DEF,
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int SYNC_W = SYNC_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_ack,
    output logic              timer_irq
);
    localparam int TIME_W = 2 * WORD_W;

    logic [TIME_W-1:0] time_q;
    logic [TIME_W-1:0] cmp_q;
    wr_stb_t           stb;
    logic              sync_hold;
    logic              sync_release;
    logic [SYNC_W-1:0] sync_target;

    mtmr_regif #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SYNC_W(SYNC_W)) u_regif (
        .req          (bus_req),
        .we           (bus_we),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .sync_release (sync_release),
        .time_q       (time_q),
        .cmp_q        (cmp_q),
        .ack          (bus_ack),
        .rdata        (bus_rdata),
        .stb          (stb),
        .sync_hold    (sync_hold),
        .sync_target  (sync_target)
    );

    mtmr_counter #(.WORD_W(WORD_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .ld_lo   (stb.time_lo),
        .ld_hi   (stb.time_hi),
        .ld_data (bus_wdata),
        .count   (time_q)
    );

    mtmr_compare #(.WORD_W(WORD_W)) u_compare (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (stb.cmp_lo),
        .wr_hi    (stb.cmp_hi),
        .disarm   (stb.cmp_off),
        .wdata    (bus_wdata),
        .time_now (time_q),
        .cmp_val  (cmp_q),
        .irq      (timer_irq)
    );

    mtmr_sync_wait #(.SYNC_W(SYNC_W)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .hold        (sync_hold),
        .target      (sync_target),
        .time_low    (time_q[SYNC_W-1:0]),
        .release_now (sync_release)
    );

    // R9: no acknowledge without a request
    p_ack_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        bus_ack |-> bus_req);

    // R8: a released wait lands on the requested tick
    p_sync_exact_r8: assert property (@(posedge clk) disable iff (rst)
        bus_ack && sync_hold |-> time_q[SYNC_W-1:0] == bus_wdata[SYNC_W-1:0]);

    // R7: reset leaves the line low
    p_reset_quiet_r7: assert property (@(posedge clk)
        $past(rst) |-> !timer_irq);
endmodule

// File: tb/mtimer_blk_tb.sv
`timescale 1ns/1ps
module mtimer_blk_tb;
    localparam logic [4:0] A_TLO = 5'h00, A_THI = 5'h04, A_CLO = 5'h08,
                           A_CHI = 5'h0C, A_SYNC = 5'h10, A_OFF = 5'h14, A_UNM = 5'h18;

    // Stall lengths to aim the wait register at, in cycles
    localparam int unsigned SYNC_VEC [6] = '{0, 1, 2, 77, 254, 255};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        timer_irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mtimer_blk u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .timer_irq (timer_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic w, input logic [4:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int stalls);
        @(negedge clk);
        bus_req = 1'b1; bus_we = w; bus_addr = a; bus_wdata = d;
        stalls = 0;
        #0.5;
        while (!bus_ack && stalls < 1000) begin
            @(negedge clk);
            #0.5;
            stalls++;
        end
        rd = bus_rdata;
        @(posedge clk);
        #0.1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
        int s;
        xfer(1'b0, a, 32'h0, v, s);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        logic [31:0] v;
        int s;
        xfer(1'b1, a, d, v, s);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v, v2, tgt;
        int st, n;

        repeat (4) @(posedge clk);
        #0.1 rst = 1'b0;

        // Reset state
        @(negedge clk); #0.5;
        chk("R7 irq after reset", timer_irq, 0);
        chk("R9 ack idle", bus_ack, 0);
        rd_reg(A_CLO, v); chk("R7 cmp lo reset", v, 32'hFFFF_FFFF);
        rd_reg(A_CHI, v); chk("R7 cmp hi reset", v, 32'hFFFF_FFFF);
        rd_reg(A_THI, v); chk("R1 time hi after reset", v, 0);

        // R1: back-to-back reads differ by one
        rd_reg(A_TLO, v); rd_reg(A_TLO, v2);
        chk("R1 step", v2 - v, 1);

        // R3/R9: zero reads, same-cycle ack
        xfer(1'b0, A_SYNC, 0, v, st); chk("R3 read sync reg", v, 0); chk("R9 read no stall", st, 0);
        xfer(1'b0, A_OFF, 0, v, st);  chk("R3 read off reg", v, 0);
        xfer(1'b0, A_UNM, 0, v, st);  chk("R3 read unmapped", v, 0);

        // R8: table of wait distances
        foreach (SYNC_VEC[i]) begin
            rd_reg(A_TLO, v);
            tgt = v + 32'd1 + SYNC_VEC[i];
            xfer(1'b1, A_SYNC, {24'hA5C3E1, tgt[7:0]}, v2, st);
            chk($sformatf("R8 stall for distance %0d", SYNC_VEC[i]), st, SYNC_VEC[i]);
            rd_reg(A_TLO, v2);
            chk($sformatf("R8 alignment for distance %0d", SYNC_VEC[i]), v2[7:0], tgt[7:0] + 8'd1);
        end

        // R4: arm compare 20 ahead, measure the rise
        rd_reg(A_TLO, v);
        wr_reg(A_CHI, 32'h0);
        wr_reg(A_CLO, v + 32'd20);
        n = 0;
        @(negedge clk); #0.5;
        while (!timer_irq && n < 100) begin
            n++;
            @(negedge clk); #0.5;
        end
        chk("R4 irq rise cycle", n, 17);

        // R5: stays high
        n = 0;
        repeat (10) begin
            @(negedge clk); #0.5;
            if (timer_irq) n++;
        end
        chk("R5 irq held", n, 10);

        // R10: unmapped write changes nothing
        wr_reg(A_UNM, 32'h0);
        @(negedge clk); #0.5;
        chk("R10 irq unchanged", timer_irq, 1);
        rd_reg(A_CLO, v2); chk("R10 cmp lo unchanged", v2, v + 32'd20);

        // R6: disarm
        wr_reg(A_OFF, 32'h0);
        @(negedge clk); #0.5;
        chk("R6 irq dropped", timer_irq, 0);
        rd_reg(A_CLO, v); chk("R6 cmp lo ones", v, 32'hFFFF_FFFF);
        rd_reg(A_CHI, v); chk("R6 cmp hi ones", v, 32'hFFFF_FFFF);

        // R4 rearm at zero, R5 move to future
        wr_reg(A_CHI, 32'h0);
        wr_reg(A_CLO, 32'h0);
        @(negedge clk); #0.5;
        chk("R4 rearm fires", timer_irq, 1);
        wr_reg(A_CLO, 32'hFFFF_0000);
        @(negedge clk); #0.5;
        chk("R5 future compare clears", timer_irq, 0);
        wr_reg(A_OFF, 32'h1);

        // R2: time word writes
        wr_reg(A_THI, 32'h5);
        rd_reg(A_THI, v); chk("R2 time hi written", v, 32'h5);
        wr_reg(A_TLO, 32'h1234);
        rd_reg(A_TLO, v); chk("R2 time lo loaded", v, 32'h1234);
        rd_reg(A_TLO, v); chk("R2 counts on", v, 32'h1235);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule